// File: doc/BRIEF.md
# Windowed Register File

This block holds the 32 integer registers of a processor core, arranged as four groups of eight: globals, outputs, locals and inputs. Two combinational read ports and one write port address the registers by a 5-bit number. A procedure call issues a save command. The current input group goes onto an on-chip frame stack, the caller's outputs become the callee's inputs, and the locals start at zero. A return issues a restore command, which undoes this: inputs move back to the outputs, the locals are cleared, and the inputs are reloaded from the newest stacked frame. Globals are untouched by either command.

The frame stack keeps eight frames on chip. A save that finds it full first spills the oldest frame to memory. A restore that finds it empty first fills one frame back from memory. Both transfers run over a valid/ready word port, one register per accepted beat. A frame pointer steps down by eight words on each spill and up by eight on each fill. While a transfer runs, the block reports busy and ignores commands and writes.

Top module: `rw_regfile`

## Requirements
- R1: Register 0 always reads as zero, and a write to it has no effect.
- R2: A write to registers 1..31 is visible on both read ports from the next cycle. A read of the register being written in the same cycle returns the new data (write-first).
- R3: Register numbers map to groups as follows: 0..7 global, 8..15 output, 16..23 local, 24..31 input. A save copies the outputs into the inputs and clears the locals. It leaves the globals and outputs unchanged and pushes the old inputs as a frame. When save and restore are requested together, only the save acts.
- R4: A restore copies the inputs into the outputs, clears the locals, and reloads the inputs from the most recently pushed frame. It leaves the globals unchanged.
- R5: Up to 8 frames are held with no memory traffic (memValid stays low).
- R6: A save with 8 frames held first spills the oldest frame. This takes 8 write beats with memWrite=1, and word i goes to address FP-8+i. The frame pointer then becomes FP-8, and the save then completes.
- R7: A restore with no frame held first fills 8 words with memWrite=0 from addresses FP+i into the frame's word i. The frame pointer then becomes FP+8, and the restore then completes.
- R8: busy is high from the cycle after a save or restore that needs memory until that command has completed. While busy, save, restore and writes are ignored.
- R9: A write requested in the same cycle as a save or restore is dropped.
- R10: While memValid is high and memReady is low, memValid, memWrite, memAddr and memWdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| saveReq | input | 1 | Save command |
| restoreReq | input | 1 | Restore command |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Write register number |
| wrData | input | 32 | Write data |
| rdAddrA | input | 5 | Read port A register number |
| rdDataA | output | 32 | Read port A data |
| rdAddrB | input | 5 | Read port B register number |
| rdDataB | output | 32 | Read port B data |
| busy | output | 1 | Spill or fill in progress |
| memValid | output | 1 | Memory beat request |
| memWrite | output | 1 | 1 = spill write, 0 = fill read |
| memAddr | output | 32 | Word address of the beat |
| memWdata | output | 32 | Spill data |
| memReady | input | 1 | Beat accepted this cycle |
| memRdata | input | 32 | Fill data, valid while memReady is high |

## Verification
Reads are combinational. The bench therefore checks a write one cycle after the edge that captures it. It checks the same-cycle bypass before that edge, with the write still driven. A save or restore that needs no memory completes at its command edge, so the group contents are checked right after that edge. A spill or fill raises busy at the command edge and then needs 8 accepted beats. The bench's memory accepts only on every other cycle, and one more apply cycle follows the beats. The bench therefore polls busy and samples the registers only after it falls. It logs memory beats at the falling clock edge so that address and data are compared where they are stable.

// File: rtl/rw_pkg.sv
package rw_pkg;

  // group codes: upper two bits of a register number
  localparam logic [1:0] GRP_GLOBAL = 2'd0;
  localparam logic [1:0] GRP_OUT    = 2'd1;
  localparam logic [1:0] GRP_LOCAL  = 2'd2;
  localparam logic [1:0] GRP_IN     = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SPILL,
    ST_FILL,
    ST_APPLY
  } rw_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic doSave;
    logic doRestore;
    logic doWrite;
    logic fillWe;
  } rw_strobe_t;

endpackage

// File: rtl/rw_ctrl.sv
module rw_ctrl
  import rw_pkg::*;
#(
  parameter int GRP_N   = 8,
  parameter int FRAMES  = 8,
  parameter int MADDR_W = 32,
  parameter logic [MADDR_W-1:0] FP_INIT = 32'h0000_0400,
  localparam int FIDX_W = $clog2(FRAMES),
  localparam int CNT_W  = $clog2(FRAMES + 1),
  localparam int BEAT_W = $clog2(GRP_N)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               saveReq,
  input  logic               restoreReq,
  input  logic               wrEn,
  input  logic               memReady,
  output rw_strobe_t         strb,
  output logic [FIDX_W-1:0]  pushIdx,
  output logic [FIDX_W-1:0]  popIdx,
  output logic [FIDX_W-1:0]  xferIdx,
  output logic [BEAT_W-1:0]  beat,
  output logic               busy,
  output logic               memValid,
  output logic               memWrite,
  output logic [MADDR_W-1:0] memAddr
);

  rw_state_t          state;
  logic               pendSave;
  logic [FIDX_W-1:0]  base;
  logic [CNT_W-1:0]   count;
  logic [MADDR_W-1:0] fp;

  logic idle, full, empty, cmdSave, cmdRest, beatFire, lastBeat;

  assign idle     = (state == ST_IDLE);
  assign full     = (count == CNT_W'(FRAMES));
  assign empty    = (count == '0);
  assign cmdSave  = idle && saveReq;
  assign cmdRest  = idle && restoreReq && !saveReq;
  assign memValid = (state == ST_SPILL) || (state == ST_FILL);
  assign memWrite = (state == ST_SPILL);
  assign beatFire = memValid && memReady;
  assign lastBeat = (beat == BEAT_W'(GRP_N - 1));
  assign busy     = !idle;

  always_comb begin
    strb.doSave    = (cmdSave && !full) || (state == ST_APPLY && pendSave);
    strb.doRestore = (cmdRest && !empty) || (state == ST_APPLY && !pendSave);
    strb.doWrite   = idle && wrEn && !saveReq && !restoreReq;
    strb.fillWe    = (state == ST_FILL) && memReady;
  end

  assign pushIdx = base + count[FIDX_W-1:0];
  assign popIdx  = base + count[FIDX_W-1:0] - FIDX_W'(1);
  assign xferIdx = (state == ST_SPILL) ? base : base - FIDX_W'(1);
  assign memAddr = (state == ST_SPILL) ? fp - MADDR_W'(GRP_N) + MADDR_W'(beat)
                                       : fp + MADDR_W'(beat);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pendSave <= 1'b0;
      base     <= '0;
      count    <= '0;
      fp       <= FP_INIT;
      beat     <= '0;
    end else begin
      if (strb.doSave)    count <= count + CNT_W'(1);
      if (strb.doRestore) count <= count - CNT_W'(1);
      unique case (state)
        ST_IDLE: begin
          beat <= '0;
          if (cmdSave && full) begin
            state    <= ST_SPILL;
            pendSave <= 1'b1;
          end else if (cmdRest && empty) begin
            state    <= ST_FILL;
            pendSave <= 1'b0;
          end
        end
        ST_SPILL: if (beatFire) begin
          beat <= beat + BEAT_W'(1);
          if (lastBeat) begin
            base  <= base + FIDX_W'(1);
            count <= count - CNT_W'(1);
            fp    <= fp - MADDR_W'(GRP_N);
            state <= ST_APPLY;
          end
        end
        ST_FILL: if (beatFire) begin
          beat <= beat + BEAT_W'(1);
          if (lastBeat) begin
            base  <= base - FIDX_W'(1);
            count <= count + CNT_W'(1);
            fp    <= fp + MADDR_W'(GRP_N);
            state <= ST_APPLY;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // frames held never exceed the on-chip depth
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(FRAMES));

  // a spill only runs with a full stack, a fill only with an empty one
  assert_spill_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SPILL) |-> full);
  assert_fill_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL) |-> empty);

  // frame pointer steps by one frame when a transfer ends
  assert_fp_down_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SPILL && beatFire && lastBeat) |=> (fp == $past(fp) - MADDR_W'(GRP_N)));
  assert_fp_up_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL && beatFire && lastBeat) |=> (fp == $past(fp) + MADDR_W'(GRP_N)));

  // a stalled beat keeps its request
  assert_hold_beat_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWrite)));

  // nothing is written while a transfer is in flight
  assert_busy_block_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.doWrite);

endmodule

// File: rtl/rw_datapath.sv
module rw_datapath
  import rw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int GRP_N  = 8,
  parameter int FRAMES = 8,
  localparam int FIDX_W = $clog2(FRAMES),
  localparam int BEAT_W = $clog2(GRP_N),
  localparam int RA_W   = BEAT_W + 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rw_strobe_t                  strb,
  input  logic [FIDX_W-1:0]           pushIdx,
  input  logic [FIDX_W-1:0]           popIdx,
  input  logic [FIDX_W-1:0]           xferIdx,
  input  logic [BEAT_W-1:0]           beat,
  input  logic [RA_W-1:0]             wrAddr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [1:0][RA_W-1:0]        rdAddr,
  output logic [1:0][DATA_W-1:0]      rdData,
  input  logic [DATA_W-1:0]           memRdata,
  output logic [DATA_W-1:0]           memWdata
);

  logic [DATA_W-1:0] bank [4][GRP_N];
  logic [DATA_W-1:0] frm  [FRAMES][GRP_N];

  logic [1:0]        wGrp;
  logic [BEAT_W-1:0] wIdx;
  logic              wLive;

  assign wGrp  = wrAddr[RA_W-1 -: 2];
  assign wIdx  = wrAddr[BEAT_W-1:0];
  assign wLive = strb.doWrite && (wrAddr != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int g = 0; g < 4; g++)
        for (int i = 0; i < GRP_N; i++) bank[g][i] <= '0;
      for (int f = 0; f < FRAMES; f++)
        for (int i = 0; i < GRP_N; i++) frm[f][i] <= '0;
    end else begin
      if (wLive) bank[wGrp][wIdx] <= wrData;
      if (strb.doSave) begin
        for (int i = 0; i < GRP_N; i++) begin
          frm[pushIdx][i]   <= bank[GRP_IN][i];
          bank[GRP_IN][i]   <= bank[GRP_OUT][i];
          bank[GRP_LOCAL][i] <= '0;
        end
      end else if (strb.doRestore) begin
        for (int i = 0; i < GRP_N; i++) begin
          bank[GRP_OUT][i]   <= bank[GRP_IN][i];
          bank[GRP_IN][i]    <= frm[popIdx][i];
          bank[GRP_LOCAL][i] <= '0;
        end
      end
      if (strb.fillWe) frm[xferIdx][beat] <= memRdata;
    end
  end

  assign memWdata = frm[xferIdx][beat];

  // read ports, write-first bypass, register 0 hard zero
  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      if (rdAddr[p] == '0)
        rdData[p] = '0;
      else if (wLive && (wrAddr == rdAddr[p]))
        rdData[p] = wrData;
      else
        rdData[p] = bank[rdAddr[p][RA_W-1 -: 2]][rdAddr[p][BEAT_W-1:0]];
    end
  end

  logic localZero;
  always_comb begin
    localZero = 1'b1;
    for (int i = 0; i < GRP_N; i++)
      if (bank[GRP_LOCAL][i] != '0) localZero = 1'b0;
  end

  // register 0 never returns data
  assert_zero_reg_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr[0] == '0) |-> (rdData[0] == '0));

  // a window move leaves the locals cleared
  assert_local_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doSave || strb.doRestore) |=> localZero);

  // the new inputs of a save are the old outputs
  assert_save_shift_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.doSave |=> (bank[GRP_IN][0] == $past(bank[GRP_OUT][0])));

  // the new outputs of a restore are the old inputs
  assert_rest_shift_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.doRestore |=> (bank[GRP_OUT][0] == $past(bank[GRP_IN][0])));

endmodule

// File: rtl/rw_regfile.sv
module rw_regfile
  import rw_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GRP_N   = 8,
  parameter int FRAMES  = 8,
  parameter int MADDR_W = 32,
  parameter logic [MADDR_W-1:0] FP_INIT = 32'h0000_0400,
  localparam int FIDX_W = $clog2(FRAMES),
  localparam int BEAT_W = $clog2(GRP_N),
  localparam int RA_W   = BEAT_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               saveReq,
  input  logic               restoreReq,
  input  logic               wrEn,
  input  logic [RA_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [RA_W-1:0]    rdAddrA,
  output logic [DATA_W-1:0]  rdDataA,
  input  logic [RA_W-1:0]    rdAddrB,
  output logic [DATA_W-1:0]  rdDataB,
  output logic               busy,
  output logic               memValid,
  output logic               memWrite,
  output logic [MADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0]  memWdata,
  input  logic               memReady,
  input  logic [DATA_W-1:0]  memRdata
);

  rw_strobe_t         strb;
  logic [FIDX_W-1:0]  pushIdx, popIdx, xferIdx;
  logic [BEAT_W-1:0]  beat;
  logic [1:0][DATA_W-1:0] rdData;

  rw_ctrl #(
    .GRP_N(GRP_N), .FRAMES(FRAMES), .MADDR_W(MADDR_W), .FP_INIT(FP_INIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .saveReq(saveReq), .restoreReq(restoreReq),
    .wrEn(wrEn), .memReady(memReady), .strb(strb), .pushIdx(pushIdx),
    .popIdx(popIdx), .xferIdx(xferIdx), .beat(beat), .busy(busy),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr)
  );

  rw_datapath #(
    .DATA_W(DATA_W), .GRP_N(GRP_N), .FRAMES(FRAMES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pushIdx(pushIdx), .popIdx(popIdx),
    .xferIdx(xferIdx), .beat(beat), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr({rdAddrB, rdAddrA}), .rdData(rdData), .memRdata(memRdata),
    .memWdata(memWdata)
  );

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];

endmodule

// File: tb/rw_regfile_bench.sv
module rw_regfile_bench;

  localparam logic [31:0] FP0 = 32'h0000_0400;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        saveReq = 1'b0, restoreReq = 1'b0, wrEn = 1'b0;
  logic [4:0]  wrAddr = '0, rdAddrA = '0, rdAddrB = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdDataA, rdDataB, memAddr, memWdata, memRdata;
  logic        busy, memValid, memWrite;
  logic        memReady = 1'b0;

  logic [31:0] benchMem [0:255];
  int testsRun = 0, testsFail = 0;
  int wrBeats = 0, rdBeats = 0, memCycles = 0;
  int addrBad = 0;

  always #4 clk = ~clk;  // 125 MHz

  rw_regfile u_rw_regfile (
    .clk(clk), .rstN(rstN), .saveReq(saveReq), .restoreReq(restoreReq),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddrA(rdAddrA),
    .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB), .busy(busy),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memReady(memReady), .memRdata(memRdata)
  );

  // memory model: accepts on every other cycle
  always @(posedge clk) memReady <= rstN ? ~memReady : 1'b0;
  assign memRdata = benchMem[memAddr[7:0]];

  always @(negedge clk) begin
    if (memValid) memCycles++;
    if (memValid && memReady) begin
      if (memWrite) begin
        if (memAddr != FP0 - 32'd8 + 32'(wrBeats)) addrBad++;
        benchMem[memAddr[7:0]] = memWdata;
        wrBeats++;
      end else begin
        if (memAddr != FP0 - 32'd8 + 32'(rdBeats)) addrBad++;
        rdBeats++;
      end
    end
  end

  // entries: {register, write data, expected read}
  localparam logic [68:0] VEC [0:7] = '{
    {5'd0,  32'hDEAD_BEEF, 32'h0000_0000},
    {5'd1,  32'h0000_0007, 32'h0000_0007},
    {5'd31, 32'h1234_5678, 32'h1234_5678},
    {5'd8,  32'hA5A5_0008, 32'hA5A5_0008},
    {5'd16, 32'h0F0F_0010, 32'h0F0F_0010},
    {5'd24, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {5'd7,  32'h8000_0000, 32'h8000_0000},
    {5'd15, 32'h0000_0001, 32'h0000_0001}
  };

  function automatic logic [31:0] fv(int k, int i);
    return 32'h5000_0000 | 32'(k << 8) | 32'(i);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic writeReg(logic [4:0] a, logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic readA(logic [4:0] a, output logic [31:0] v);
    rdAddrA = a;
    #1;
    v = rdDataA;
  endtask

  task automatic waitIdle();
    while (busy) tick();
  endtask

  task automatic cmd(bit isSave);
    if (isSave) saveReq = 1'b1; else restoreReq = 1'b1;
    tick();
    saveReq = 1'b0; restoreReq = 1'b0;
    waitIdle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFail++;
    $display("FAIL R8 watchdog actual=hung expected=idle");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int a = 0; a < 256; a++) benchMem[a] = '0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // reset state
    check("R8 reset busy", 32'(busy), 32'd0);
    check("R5 reset memValid", 32'(memValid), 32'd0);
    readA(5'd20, v); check("R2 reset register", v, 32'd0);

    // table walk: write then read on port A next cycle (R1, R2)
    for (int n = 0; n < 8; n++) begin
      writeReg(VEC[n][68:64], VEC[n][63:32]);
      readA(VEC[n][68:64], v);
      check($sformatf("R1/R2 vector %0d", n), v, VEC[n][31:0]);
    end

    // same-cycle write-first bypass on port B (R2)
    wrEn = 1'b1; wrAddr = 5'd9; wrData = 32'hCAFE_0009; rdAddrB = 5'd9;
    #1; check("R2 bypass", rdDataB, 32'hCAFE_0009);
    tick(); wrEn = 1'b0;
    // bypass must not fire for register 0 (R1)
    wrEn = 1'b1; wrAddr = 5'd0; wrData = 32'h1111_1111; rdAddrB = 5'd0;
    #1; check("R1 bypass zero", rdDataB, 32'd0);
    tick(); wrEn = 1'b0;

    // plain save (R3)
    for (int i = 0; i < 8; i++) begin
      writeReg(5'(8 + i),  32'(100 + i));
      writeReg(5'(16 + i), 32'(200 + i));
      writeReg(5'(24 + i), 32'(300 + i));
    end
    memCycles = 0;
    cmd(1'b1);
    for (int i = 0; i < 8; i++) begin
      readA(5'(24 + i), v); check("R3 save in<-out", v, 32'(100 + i));
      readA(5'(16 + i), v); check("R3 save local clear", v, 32'd0);
    end
    readA(5'd8, v); check("R3 save out kept", v, 32'd100);
    readA(5'd1, v); check("R3 save global kept", v, 32'd7);

    // plain restore (R4)
    writeReg(5'd17, 32'h77);
    cmd(1'b0);
    for (int i = 0; i < 8; i++) begin
      readA(5'(24 + i), v); check("R4 restore in<-frame", v, 32'(300 + i));
      readA(5'(8 + i), v);  check("R4 restore out<-in", v, 32'(100 + i));
    end
    readA(5'd17, v); check("R4 restore local clear", v, 32'd0);
    readA(5'd1, v);  check("R4 restore global kept", v, 32'd7);

    // save and restore together: save only (R3)
    saveReq = 1'b1; restoreReq = 1'b1; tick(); saveReq = 1'b0; restoreReq = 1'b0;
    readA(5'd24, v); check("R3 save wins", v, 32'd100);
    cmd(1'b0);

    // eight saves stay on chip (R5)
    memCycles = 0;
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 8; i++) writeReg(5'(24 + i), fv(k, i));
      cmd(1'b1);
    end
    check("R5 no traffic for 8 frames", 32'(memCycles), 32'd0);

    // ninth save spills the oldest frame (R6, R8, R10)
    for (int i = 0; i < 8; i++) writeReg(5'(24 + i), fv(8, i));
    saveReq = 1'b1; tick(); saveReq = 1'b0;
    check("R8 busy after spill command", 32'(busy), 32'd1);
    wrEn = 1'b1; wrAddr = 5'd1; wrData = 32'hDEAD_0001; restoreReq = 1'b1;
    tick();
    wrEn = 1'b0; restoreReq = 1'b0;
    waitIdle();
    check("R6 spill beats", 32'(wrBeats), 32'd8);
    check("R6/R10 spill addresses", 32'(addrBad), 32'd0);
    for (int i = 0; i < 8; i++)
      check("R6 spilled word", benchMem[8'hF8 + i], fv(0, i));
    readA(5'd1, v);  check("R8 write ignored while busy", v, 32'd7);
    readA(5'd24, v); check("R6 save after spill", v, 32'd100);

    // restores pop frames 8..1 without traffic (R4, R5, R8)
    memCycles = 0;
    for (int j = 0; j < 8; j++) begin
      cmd(1'b0);
      readA(5'd24, v); check("R4/R8 pop order", v, fv(8 - j, 0));
    end
    check("R5 no traffic on pops", 32'(memCycles), 32'd0);

    // empty stack: restore fills frame 0 back (R7)
    cmd(1'b0);
    check("R7 fill beats", 32'(rdBeats), 32'd8);
    check("R7 fill addresses", 32'(addrBad), 32'd0);
    for (int i = 0; i < 8; i++) begin
      readA(5'(24 + i), v); check("R7 filled input", v, fv(0, i));
    end
    readA(5'd8, v); check("R7 out after fill", v, fv(1, 0));

    // write with a save is dropped (R9)
    wrEn = 1'b1; wrAddr = 5'd1; wrData = 32'h0000_0099; saveReq = 1'b1;
    tick();
    wrEn = 1'b0; saveReq = 1'b0;
    waitIdle();
    readA(5'd1, v); check("R9 write with save dropped", v, 32'd7);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule